// File: doc/BRIEF.md
# Paged Switch Register Access Sequencer

This block lets a host reach the 32-bit registers of an Ethernet switch that is only visible through a 16-bit management bus. One request names a switch register address, a direction and, for writes, a 32-bit value. The sequencer turns it into a short run of 16-bit transactions on a request/acknowledge port that feeds an MDIO master. First it writes a page number. Then it moves the two half-words through a pseudo PHY address and a register pair, both taken from the switch address. A mode input picks which of two page-register locations the attached switch uses.

A second kind of request reaches a PHY behind the switch through the switch's own indirect command register. The sequencer does a dummy read of that register and then writes a command word. It then reads the register again and again until the busy flag clears, and returns the 16-bit data field. Every request ends with a one-cycle done pulse, together with an error flag when the management port reported a failure.

Top module: `swreg_pager`

## Requirements
- R1: Each switch-register access begins with a write of the address shifted right by 9. This write goes to PHY 0x1F register 0x10 when mode is 0, and to PHY 0x18 register 0x00 when mode is 1.
- R2: The half-word transactions use PHY address ((addr >> 6) & 7) | 0x10. The low half sits at register (addr >> 1) & 0x1E and the high half at that register | 1.
- R3: A direct read fetches the low half and then the high half. It returns {high, low} on rdata.
- R4: A direct write in mode 0 to address 0x98 sends the low half first. Every other direct write sends the high half first.
- R5: An indirect access uses a command word at switch address 0x98. The word holds data in bits 15:0 (zero for a read), the PHY register in bits 20:16 and the PHY address in bits 25:21. Bit 27 is set for a read, and bits 31 and 30 are both set.
- R6: An indirect access does a full read of 0x98, then a full write of the command word to 0x98, then full reads of 0x98. The reads repeat while bit 31 of the value read is 1. The block then returns {16'h0, bits 15:0} of the last read.
- R7: If the management port acknowledges with m_err high, the sequence stops with no further transaction. done and err both go high in that cycle and rdata reads 0.
- R8: A request is taken only while req_ready is high (idle). req_valid during a sequence is ignored, and m_req is never high while req_ready is high.
- R9: done is a single-cycle pulse. rdata and err change only in a done cycle and otherwise hold. A successful direct write returns rdata 0.
- R10: m_req stays high until a cycle in which m_ack is high. While it waits, m_wr, m_phy, m_reg and m_wdata hold steady. m_wr is 1 for the page write and for data writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Start a request (taken when req_ready) |
| req_write | input | 1 | 1 = write, 0 = read |
| req_indirect | input | 1 | 1 = PHY access through the switch command register |
| req_mode | input | 1 | Page-register location select |
| req_addr | input | ADDR_W | Switch register address (direct access) |
| req_wdata | input | 32 | Write data; bits 15:0 are the PHY data for indirect writes |
| req_phy | input | 5 | PHY address for indirect access |
| req_preg | input | 5 | PHY register for indirect access |
| req_ready | output | 1 | Idle, a request may be issued |
| m_req | output | 1 | Management transaction request |
| m_wr | output | 1 | Transaction is a write |
| m_phy | output | 5 | Transaction PHY address |
| m_reg | output | 5 | Transaction register number |
| m_wdata | output | 16 | Transaction write data |
| m_ack | input | 1 | Transaction complete |
| m_err | input | 1 | Transaction failed (valid with m_ack) |
| m_rdata | input | 16 | Transaction read data (valid with m_ack) |
| done | output | 1 | One-cycle completion pulse |
| err | output | 1 | Last request failed |
| rdata | output | 32 | Result of the last request |

## Verification
The bound checker watches the handshake rules on every cycle. A pending transaction holds its request and fields until acknowledged, and no transaction appears while idle. done lasts one cycle, rdata and err move only on done, and a new error comes with done. Address splitting, page location, half ordering, the command-word layout and the polling loop depend on values and order. Only the bench's scenarios show these: its responder compares each transaction in order against what it expects. The same goes for the stop after an error and the rejection of requests that arrive while busy.

// File: rtl/swreg_pager_pkg.sv
package swreg_pager_pkg;
  localparam int HALF_W     = 16;
  localparam int WORD_W     = 32;
  localparam int PHY_W      = 5;
  localparam int REG_W      = 5;
  localparam int PAGE_SHIFT = 9;
  localparam int CMD_ADDR   = 'h98;

  localparam logic [PHY_W-1:0] PG_PHY_M0 = 5'h1F;
  localparam logic [REG_W-1:0] PG_REG_M0 = 5'h10;
  localparam logic [PHY_W-1:0] PG_PHY_M1 = 5'h18;
  localparam logic [REG_W-1:0] PG_REG_M1 = 5'h00;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_WAIT} state_e;
  typedef enum logic [1:0] {PH_DIRECT, PH_DUMMY, PH_CMD, PH_POLL} phase_e;
  typedef enum logic [1:0] {STEP_PAGE = 2'd0, STEP_FIRST = 2'd1, STEP_SECOND = 2'd2} step_e;

  // Command word: start bits on top, read flag at 27, PHY at 25:21, register at 20:16.
  function automatic logic [WORD_W-1:0] build_cmd(input logic rd,
                                                  input logic [PHY_W-1:0] phy,
                                                  input logic [REG_W-1:0] rg,
                                                  input logic [HALF_W-1:0] dat);
    return {2'b11, 2'b00, rd, 1'b0, phy, rg, (rd ? {HALF_W{1'b0}} : dat)};
  endfunction
endpackage

// File: rtl/swreg_pager_map.sv
module swreg_pager_map
  import swreg_pager_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              mode,
  input  logic [ADDR_W-1:0] addr,
  input  logic              write,
  input  logic [WORD_W-1:0] data,
  input  step_e             step,
  output logic [PHY_W-1:0]  phy,
  output logic [REG_W-1:0]  regn,
  output logic [HALF_W-1:0] wdata
);
  localparam int PAGE_W = ADDR_W - PAGE_SHIFT;

  logic [PAGE_W-1:0] page;
  logic [PHY_W-1:0]  half_phy;
  logic [REG_W-1:0]  base_reg;
  logic              low_first_wr;
  logic              hi_first;
  logic              take_hi;

  assign page         = addr[ADDR_W-1:PAGE_SHIFT];
  assign half_phy     = {2'b10, addr[8:6]};
  assign base_reg     = {addr[5:2], 1'b0};
  assign low_first_wr = !mode && (addr == ADDR_W'(CMD_ADDR));
  assign hi_first     = write && !low_first_wr;
  assign take_hi      = (step == STEP_FIRST) ? hi_first : !hi_first;

  always_comb begin
    if (step == STEP_PAGE) begin
      phy   = mode ? PG_PHY_M1 : PG_PHY_M0;
      regn  = mode ? PG_REG_M1 : PG_REG_M0;
      wdata = HALF_W'(page);
    end else begin
      phy   = half_phy;
      regn  = base_reg | REG_W'(take_hi);
      wdata = take_hi ? data[WORD_W-1:HALF_W] : data[HALF_W-1:0];
    end
  end
endmodule

// File: rtl/swreg_pager_lohold.sv
module swreg_pager_lohold
  import swreg_pager_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              en,
  input  logic [HALF_W-1:0] d,
  output logic [HALF_W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst)     q <= '0;
    else if (en) q <= d;
  end
endmodule

// File: rtl/swreg_pager_ctrl.sv
module swreg_pager_ctrl
  import swreg_pager_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_indirect,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [WORD_W-1:0] req_wdata,
  input  logic [PHY_W-1:0]  req_phy,
  input  logic [REG_W-1:0]  req_preg,
  output logic              req_ready,
  output logic              op_mode,
  output logic [ADDR_W-1:0] op_addr,
  output logic              op_write,
  output logic [WORD_W-1:0] op_data,
  output step_e             step,
  input  logic [PHY_W-1:0]  map_phy,
  input  logic [REG_W-1:0]  map_reg,
  input  logic [HALF_W-1:0] map_wdata,
  output logic              m_req,
  output logic              m_wr,
  output logic [PHY_W-1:0]  m_phy,
  output logic [REG_W-1:0]  m_reg,
  output logic [HALF_W-1:0] m_wdata,
  input  logic              m_ack,
  input  logic              m_err,
  input  logic [HALF_W-1:0] m_rdata,
  output logic              cap_lo,
  input  logic [HALF_W-1:0] lo_q,
  output logic              done,
  output logic              err,
  output logic [WORD_W-1:0] rdata
);
  state_e st;
  phase_e phase;

  assign req_ready = (st == ST_IDLE);
  assign cap_lo    = (st == ST_WAIT) && m_ack && !m_err && !op_write && (step == STEP_FIRST);

  always_ff @(posedge clk) begin
    if (rst) begin
      st       <= ST_IDLE;
      phase    <= PH_DIRECT;
      step     <= STEP_PAGE;
      op_mode  <= 1'b0;
      op_addr  <= '0;
      op_write <= 1'b0;
      op_data  <= '0;
      m_req    <= 1'b0;
      m_wr     <= 1'b0;
      m_phy    <= '0;
      m_reg    <= '0;
      m_wdata  <= '0;
      done     <= 1'b0;
      err      <= 1'b0;
      rdata    <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        ST_IDLE: begin
          if (req_valid) begin
            op_mode <= req_mode;
            step    <= STEP_PAGE;
            st      <= ST_SETUP;
            if (req_indirect) begin
              phase    <= PH_DUMMY;
              op_write <= 1'b0;
              op_addr  <= ADDR_W'(CMD_ADDR);
              op_data  <= build_cmd(!req_write, req_phy, req_preg, req_wdata[HALF_W-1:0]);
            end else begin
              phase    <= PH_DIRECT;
              op_write <= req_write;
              op_addr  <= req_addr;
              op_data  <= req_wdata;
            end
          end
        end
        ST_SETUP: begin
          m_req   <= 1'b1;
          m_wr    <= op_write || (step == STEP_PAGE);
          m_phy   <= map_phy;
          m_reg   <= map_reg;
          m_wdata <= map_wdata;
          st      <= ST_WAIT;
        end
        ST_WAIT: begin
          if (m_ack) begin
            m_req <= 1'b0;
            if (m_err) begin
              done  <= 1'b1;
              err   <= 1'b1;
              rdata <= '0;
              st    <= ST_IDLE;
            end else if (step == STEP_PAGE) begin
              step <= STEP_FIRST;
              st   <= ST_SETUP;
            end else if (step == STEP_FIRST) begin
              step <= STEP_SECOND;
              st   <= ST_SETUP;
            end else begin
              step <= STEP_PAGE;
              case (phase)
                PH_DIRECT: begin
                  done  <= 1'b1;
                  err   <= 1'b0;
                  rdata <= op_write ? '0 : {m_rdata, lo_q};
                  st    <= ST_IDLE;
                end
                PH_DUMMY: begin
                  phase    <= PH_CMD;
                  op_write <= 1'b1;
                  st       <= ST_SETUP;
                end
                PH_CMD: begin
                  phase    <= PH_POLL;
                  op_write <= 1'b0;
                  st       <= ST_SETUP;
                end
                default: begin
                  if (m_rdata[HALF_W-1]) begin
                    st <= ST_SETUP;
                  end else begin
                    done  <= 1'b1;
                    err   <= 1'b0;
                    rdata <= {{HALF_W{1'b0}}, lo_q};
                    st    <= ST_IDLE;
                  end
                end
              endcase
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/swreg_pager.sv
module swreg_pager
  import swreg_pager_pkg::*;
#(
  parameter int ADDR_W = 19
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic              req_indirect,
  input  logic              req_mode,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [31:0]       req_wdata,
  input  logic [4:0]        req_phy,
  input  logic [4:0]        req_preg,
  output logic              req_ready,
  output logic              m_req,
  output logic              m_wr,
  output logic [4:0]        m_phy,
  output logic [4:0]        m_reg,
  output logic [15:0]       m_wdata,
  input  logic              m_ack,
  input  logic              m_err,
  input  logic [15:0]       m_rdata,
  output logic              done,
  output logic              err,
  output logic [31:0]       rdata
);
  logic              op_mode;
  logic [ADDR_W-1:0] op_addr;
  logic              op_write;
  logic [WORD_W-1:0] op_data;
  step_e             step;
  logic [PHY_W-1:0]  map_phy;
  logic [REG_W-1:0]  map_reg;
  logic [HALF_W-1:0] map_wdata;
  logic              cap_lo;
  logic [HALF_W-1:0] lo_q;

  swreg_pager_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_write(req_write), .req_indirect(req_indirect),
    .req_mode(req_mode), .req_addr(req_addr), .req_wdata(req_wdata),
    .req_phy(req_phy), .req_preg(req_preg), .req_ready(req_ready),
    .op_mode(op_mode), .op_addr(op_addr), .op_write(op_write), .op_data(op_data),
    .step(step), .map_phy(map_phy), .map_reg(map_reg), .map_wdata(map_wdata),
    .m_req(m_req), .m_wr(m_wr), .m_phy(m_phy), .m_reg(m_reg), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .cap_lo(cap_lo), .lo_q(lo_q),
    .done(done), .err(err), .rdata(rdata)
  );

  swreg_pager_map #(.ADDR_W(ADDR_W)) u_map (
    .mode(op_mode), .addr(op_addr), .write(op_write), .data(op_data), .step(step),
    .phy(map_phy), .regn(map_reg), .wdata(map_wdata)
  );

  swreg_pager_lohold u_lo (
    .clk(clk), .rst(rst), .en(cap_lo), .d(m_rdata), .q(lo_q)
  );
endmodule

// File: rtl/swreg_pager_chk.sv
module swreg_pager_chk (
  input logic        clk,
  input logic        rst,
  input logic        req_ready,
  input logic        m_req,
  input logic        m_ack,
  input logic        m_wr,
  input logic [4:0]  m_phy,
  input logic [4:0]  m_reg,
  input logic [15:0] m_wdata,
  input logic        done,
  input logic        err,
  input logic [31:0] rdata
);
  AST_REQ_HELD: assert property (@(posedge clk) disable iff (rst) (m_req && !m_ack) |=> m_req); // R10
  AST_FIELDS_HELD: assert property (@(posedge clk) disable iff (rst)
    (m_req && !m_ack) |=> ($stable(m_wr) && $stable(m_phy) && $stable(m_reg) && $stable(m_wdata))); // R10
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst) req_ready |-> !m_req); // R8
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (rst) done |=> !done); // R9
  AST_RDATA_AT_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(rdata) |-> done); // R9
  AST_ERR_AT_DONE: assert property (@(posedge clk) disable iff (rst) !$stable(err) |-> done); // R7
endmodule

bind swreg_pager swreg_pager_chk u_chk (
  .clk(clk), .rst(rst), .req_ready(req_ready), .m_req(m_req), .m_ack(m_ack),
  .m_wr(m_wr), .m_phy(m_phy), .m_reg(m_reg), .m_wdata(m_wdata),
  .done(done), .err(err), .rdata(rdata)
);

// File: tb/swreg_pager_test.sv
module swreg_pager_test;
  localparam int AW = 19;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          req_valid = 1'b0, req_write = 1'b0, req_indirect = 1'b0, req_mode = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [31:0]   req_wdata = '0;
  logic [4:0]    req_phy = '0, req_preg = '0;
  logic          req_ready, m_req, m_wr, done, err;
  logic [4:0]    m_phy, m_reg;
  logic [15:0]   m_wdata, m_rdata;
  logic          m_ack, m_err;
  logic [31:0]   rdata;

  int checks = 0, fails = 0, txn_seen = 0, done_cnt = 0;

  typedef struct {string tag; bit wr; logic [4:0] phy; logic [4:0] rg; logic [15:0] wd; logic [15:0] rd; bit er;} item_t;
  typedef struct {string tag; logic [31:0] rdata; bit er;} res_t;
  item_t exq[$];
  res_t  resq[$];

  always #2.5 clk = ~clk;

  swreg_pager #(.ADDR_W(AW)) uut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_indirect(req_indirect), .req_mode(req_mode), .req_addr(req_addr),
    .req_wdata(req_wdata), .req_phy(req_phy), .req_preg(req_preg), .req_ready(req_ready),
    .m_req(m_req), .m_wr(m_wr), .m_phy(m_phy), .m_reg(m_reg), .m_wdata(m_wdata),
    .m_ack(m_ack), .m_err(m_err), .m_rdata(m_rdata),
    .done(done), .err(err), .rdata(rdata)
  );

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, expv);
    end
  endtask

  task automatic push(input string tag, input bit wr, input logic [4:0] phy,
                      input logic [4:0] rg, input logic [15:0] wd,
                      input logic [15:0] rd, input bit er);
    item_t it;
    it.tag = tag; it.wr = wr; it.phy = phy; it.rg = rg; it.wd = wd; it.rd = rd; it.er = er;
    exq.push_back(it);
  endtask

  // Expected transactions of one 32-bit access, derived from R1, R2, R3, R4.
  task automatic push_access(input string tag, input bit mode, input logic [AW-1:0] a,
                             input bit wr, input logic [31:0] d,
                             input logic [15:0] lo_r, input logic [15:0] hi_r);
    logic [4:0] hp, br;
    hp = 5'(((a >> 6) & 7) | 'h10);
    br = 5'((a >> 1) & 'h1E);
    push(tag, 1, mode ? 5'h18 : 5'h1F, mode ? 5'h00 : 5'h10, 16'(a >> 9), 0, 0);
    if (!wr) begin
      push(tag, 0, hp, br, 0, lo_r, 0);
      push(tag, 0, hp, br | 5'd1, 0, hi_r, 0);
    end else if (!mode && a == 'h98) begin
      push(tag, 1, hp, br, d[15:0], 0, 0);
      push(tag, 1, hp, br | 5'd1, d[31:16], 0, 0);
    end else begin
      push(tag, 1, hp, br | 5'd1, d[31:16], 0, 0);
      push(tag, 1, hp, br, d[15:0], 0, 0);
    end
  endtask

  task automatic push_res(input string tag, input logic [31:0] r, input bit er);
    res_t x;
    x.tag = tag; x.rdata = r; x.er = er;
    resq.push_back(x);
  endtask

  // Management responder: pops and compares each transaction in order.
  initial begin
    item_t it;
    m_ack = 1'b0; m_err = 1'b0; m_rdata = '0;
    forever begin
      @(negedge clk);
      if (m_req) begin
        txn_seen++;
        if (exq.size() == 0) begin
          chk(0, "R8", "unexpected transaction phy/reg", {22'h0, m_phy, m_reg}, 32'h0);
          it.rd = '0; it.er = 0;
        end else begin
          it = exq.pop_front();
          chk(m_wr == it.wr, it.tag, "m_wr", {31'h0, m_wr}, {31'h0, it.wr});
          chk(m_phy == it.phy, it.tag, "m_phy", {27'h0, m_phy}, {27'h0, it.phy});
          chk(m_reg == it.rg, it.tag, "m_reg", {27'h0, m_reg}, {27'h0, it.rg});
          if (it.wr) chk(m_wdata == it.wd, it.tag, "m_wdata", {16'h0, m_wdata}, {16'h0, it.wd});
        end
        repeat (txn_seen % 3) @(negedge clk);
        m_ack = 1'b1; m_rdata = it.rd; m_err = it.er;
        @(negedge clk);
        m_ack = 1'b0; m_err = 1'b0;
      end
    end
  end

  // Result monitor.
  initial begin
    res_t x;
    forever begin
      @(negedge clk);
      if (done) begin
        done_cnt++;
        if (resq.size() == 0) chk(0, "R9", "unexpected done", rdata, 32'h0);
        else begin
          x = resq.pop_front();
          chk(rdata == x.rdata, x.tag, "rdata", rdata, x.rdata);
          chk(err == x.er, x.tag, "err", {31'h0, err}, {31'h0, x.er});
        end
      end
    end
  end

  task automatic issue(input bit wr, input bit ind, input bit mode, input logic [AW-1:0] a,
                       input logic [31:0] d, input logic [4:0] phy, input logic [4:0] rg);
    while (!req_ready) @(negedge clk);
    req_valid = 1; req_write = wr; req_indirect = ind; req_mode = mode;
    req_addr = a; req_wdata = d; req_phy = phy; req_preg = rg;
    @(negedge clk);
    req_valid = 0;
  endtask

  task automatic wait_done(input int target);
    while (done_cnt < target) @(negedge clk);
  endtask

  task automatic drained(input string tag);
    chk(exq.size() == 0, tag, "pending transactions", exq.size(), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R10", "watchdog expired", 0, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int tgt;
    logic [31:0] held;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk(req_ready == 1, "R8", "reset ready", {31'h0, req_ready}, 1);
    chk(m_req == 0, "R10", "reset m_req", {31'h0, m_req}, 0);
    chk(done == 0 && err == 0 && rdata == 0, "R9", "reset outputs", rdata, 0);

    // R1 R2 R3: direct read, mode 0, address 0x1234 -> page 9, phy 0x10, regs 0x1A/0x1B
    push_access("R3", 0, 'h1234, 0, 0, 16'hBEEF, 16'hCAFE);
    push_res("R3", 32'hCAFEBEEF, 0);
    tgt = done_cnt + 1; issue(0, 0, 0, 'h1234, 0, 0, 0); wait_done(tgt); drained("R3");
    held = rdata;
    repeat (5) @(negedge clk);
    chk(rdata == held && done == 0, "R9", "rdata hold after done", rdata, held);

    // R1 R4: direct write, mode 1, address 0x98 -> high half first
    push_access("R4", 1, 'h98, 1, 32'h1122_3344, 0, 0);
    push_res("R4", 0, 0);
    tgt = done_cnt + 1; issue(1, 0, 1, 'h98, 32'h1122_3344, 0, 0); wait_done(tgt); drained("R4");

    // R4: mode 0 address 0x98 -> low half first
    push_access("R4", 0, 'h98, 1, 32'hA5A5_5A5A, 0, 0);
    push_res("R4", 0, 0);
    tgt = done_cnt + 1; issue(1, 0, 0, 'h98, 32'hA5A5_5A5A, 0, 0); wait_done(tgt); drained("R4");

    // R2 R4: mode 0 address 0x40 -> phy 0x11, regs 0/1, high first; plus large page
    push_access("R2", 0, 'h40, 1, 32'hDEAD_0001, 0, 0);
    push_res("R2", 0, 0);
    tgt = done_cnt + 1; issue(1, 0, 0, 'h40, 32'hDEAD_0001, 0, 0); wait_done(tgt); drained("R2");
    push_access("R1", 1, 'h7FFFC, 0, 0, 16'h0102, 16'h0304);
    push_res("R1", 32'h03040102, 0);
    tgt = done_cnt + 1; issue(0, 0, 1, 'h7FFFC, 0, 0, 0); wait_done(tgt); drained("R1");

    // R5 R6: indirect read, mode 0, phy 3 reg 2 -> command 0xC8620000, one busy poll
    push_access("R6", 0, 'h98, 0, 0, 16'h7777, 16'h0000);
    push_access("R5", 0, 'h98, 1, 32'hC862_0000, 0, 0);
    push_access("R6", 0, 'h98, 0, 0, 16'h1111, 16'h8000);
    push_access("R6", 0, 'h98, 0, 0, 16'h5A5A, 16'h0000);
    push_res("R6", 32'h0000_5A5A, 0);
    tgt = done_cnt + 1; issue(0, 1, 0, 0, 0, 5'd3, 5'd2); wait_done(tgt); drained("R6");

    // R5 R6: indirect write, mode 1, phy 1 reg 4 data 0xABCD -> command 0xC024ABCD
    push_access("R6", 1, 'h98, 0, 0, 16'h0000, 16'h0000);
    push_access("R5", 1, 'h98, 1, 32'hC024_ABCD, 0, 0);
    push_access("R6", 1, 'h98, 0, 0, 16'h1234, 16'h7FFF);
    push_res("R6", 32'h0000_1234, 0);
    tgt = done_cnt + 1; issue(1, 1, 1, 0, 32'hFFFF_ABCD, 5'd1, 5'd4); wait_done(tgt); drained("R5");

    // R8: requests while busy are ignored
    push_access("R8", 0, 'h0204, 0, 0, 16'h4444, 16'h3333);
    push_res("R8", 32'h3333_4444, 0);
    tgt = done_cnt + 1; issue(0, 0, 0, 'h0204, 0, 0, 0);
    for (int k = 0; k < 4; k++) begin
      req_valid = 1; req_write = 1; req_addr = 'h55; req_indirect = k[0];
      chk(req_ready == 0, "R8", "ready while busy", {31'h0, req_ready}, 0);
      @(negedge clk);
    end
    req_valid = 0;
    wait_done(tgt); drained("R8");
    repeat (6) @(negedge clk);
    chk(done_cnt == tgt, "R8", "extra completion", done_cnt, tgt);

    // R7: error on the first half read aborts the sequence
    push(  "R7", 1, 5'h1F, 5'h10, 16'h0001, 0, 0);
    push(  "R7", 0, 5'h10, 5'h00, 0, 16'hFFFF, 1);
    push_res("R7", 32'h0, 1);
    tgt = done_cnt + 1; issue(0, 0, 0, 'h200, 0, 0, 0); wait_done(tgt); drained("R7");
    held = txn_seen;
    repeat (10) @(negedge clk);
    chk(txn_seen == held, "R7", "transactions after error", txn_seen, held);
    chk(err == 1, "R9", "err holds", {31'h0, err}, 1);

    // R9: next good request clears err
    push_access("R9", 0, 'h0, 0, 0, 16'h0000, 16'h0001);
    push_res("R9", 32'h0001_0000, 0);
    tgt = done_cnt + 1; issue(0, 0, 0, 'h0, 0, 0, 0); wait_done(tgt); drained("R9");

    repeat (4) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule